// File: doc/BRIEF.md
# Paged Configuration Register Bridge

This block is a memory-mapped slave on a simple two-phase bus (setup, then access, with ready and error flags). It gives the host reach into a 21-bit space of 16-bit configuration registers. Each address in that space is built from a 5-bit device number, held in bits 20:16, and a 16-bit register number, held in bits 15:0. The bridge turns every bus transfer into a single read or write on a synchronous port of a register store that it owns.

A parameter picks one of two address maps. In the flat map, every register has a bus address of its own. In the windowed map, the bus sees only 256 entries. Entry 0xFF holds a page register that supplies address bits 20:8. Entries 0x00 to 0xFE supply bits 7:0. A second parameter sets the spacing of the entries, 2 or 4 bytes. With 4-byte spacing the bus is 32 bits wide and only its low half carries register data. The store may back only a small, parameterised corner of the space, starting at device 0 and register 0.

Top module: `csr_window_bridge`

## Requirements
- R1: In the flat map (DIRECT=1) the register at device d, register r lives at bus byte address ((d<<16)|r) * STRIDE. Every aligned address below 2^21 * STRIDE is a legal transfer.
- R2: In the windowed map (DIRECT=0) a transfer to entry e (0x00..0xFE) reaches CSR address {page, e}, where page is the 13-bit page value. Writing entry 0xFF changes which registers later transfers reach.
- R3: The page value is 0 after reset. A write to entry 0xFF stores bits 12:0 of the write data and drops the upper bits. A read of entry 0xFF returns the page value, zero-extended.
- R4: The entry index is the bus byte address shifted right by 1 (STRIDE=2) or by 2 (STRIDE=4). With STRIDE=4, reads return the register in bits 15:0 with bits 31:16 zero, and bits 31:16 of write data are ignored.
- R5: A transfer whose address is not a multiple of STRIDE completes with pslverr=1 and prdata=0, and a write of this kind changes no register and no page value.
- R6: A transfer at or beyond the window end (256*STRIDE bytes windowed, 2^21*STRIDE bytes flat) completes with pslverr=1 and prdata=0, and a write of this kind changes nothing.
- R7: pready is 1 in the access phase (psel=1, penable=1) and 0 at all other times, so every transfer ends after one access cycle. A read returns the value most recently written to that register.
- R8: Only registers with device below IMPL_DEVS and register number below IMPL_REGS are backed. Any other legal register reads as 0, and writes to it are dropped without an error.
- R9: After reset every backed register reads 0. While psel=0, prdata and pslverr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | PADDR_W | Byte address |
| pwdata | input | 8*STRIDE | Write data |
| prdata | output | 8*STRIDE | Read data, valid in the access phase |
| pready | output | 1 | Transfer completes this cycle |
| pslverr | output | 1 | Error response for a misaligned or out-of-window address |

## Verification
Two bridges, one windowed with 4-byte spacing and one flat with 2-byte spacing, receive the same transfer stream. This lets a single address mean different registers to each. The bench goes after page-entry reads and writes with junk in the upper data bits. A design that kept too many page bits would move later accesses to the wrong device. It also checks unaligned and beyond-window writes followed by read-back. A design that let those through would corrupt a neighbouring register. It also checks accesses to unbacked registers, which must read zero without an error, and the upper half of the 32-bit bus, which must stay zero. Fetching stale store data at the setup edge would show up as a read mismatch right after a write.

// File: rtl/csr_window_pkg.sv
package csr_window_pkg;

  localparam int CSR_AW  = 21;
  localparam int DEV_W   = 5;
  localparam int REG_W   = 16;
  localparam int VAL_W   = 16;
  localparam int PAGE_W  = 13;
  localparam int ENTRY_W = 8;
  localparam logic [ENTRY_W-1:0] PAGE_ENTRY = 8'hFF;

  typedef struct packed {
    logic              ok;
    logic              page_sel;
    logic [CSR_AW-1:0] csr;
  } dec_t;

  // byte-address to entry-index shift for a given stride
  function automatic int stride_shift(input int stride);
    return (stride == 4) ? 2 : 1;
  endfunction

  function automatic logic [CSR_AW-1:0] csr_join(input logic [PAGE_W-1:0]  page,
                                                 input logic [ENTRY_W-1:0] entry);
    return {page, entry};
  endfunction

  function automatic logic [DEV_W-1:0] csr_dev(input logic [CSR_AW-1:0] a);
    return a[CSR_AW-1:REG_W];
  endfunction

  function automatic logic [REG_W-1:0] csr_reg(input logic [CSR_AW-1:0] a);
    return a[REG_W-1:0];
  endfunction

endpackage

// File: rtl/csr_window_decode.sv
module csr_window_decode
  import csr_window_pkg::*;
#(
  parameter int PADDR_W = 32,
  parameter bit DIRECT  = 1'b0,
  parameter int STRIDE  = 4
) (
  input  logic [PADDR_W-1:0] paddr,
  input  logic [PAGE_W-1:0]  page,
  output dec_t               dec
);
  localparam int SH = stride_shift(STRIDE);
  localparam logic [63:0] WIN_ENTRIES = DIRECT ? (64'd1 << CSR_AW) : 64'd256;

  logic [PADDR_W-1:0] idx;
  logic [63:0]        idx_wide;
  logic               misaligned;
  logic               out_of_window;

  assign idx           = paddr >> SH;
  assign idx_wide      = 64'(idx);
  assign misaligned    = |paddr[SH-1:0];
  assign out_of_window = idx_wide >= WIN_ENTRIES;
  assign dec.ok        = !misaligned && !out_of_window;

  generate
    if (DIRECT) begin : g_flat
      logic unused_page;
      assign unused_page  = ^page;
      assign dec.page_sel = 1'b0;
      assign dec.csr      = idx[CSR_AW-1:0];
    end else begin : g_window
      assign dec.page_sel = (idx[ENTRY_W-1:0] == PAGE_ENTRY);
      assign dec.csr      = csr_join(page, idx[ENTRY_W-1:0]);
    end
  endgenerate

endmodule

// File: rtl/csr_window_page.sv
module csr_window_page
  import csr_window_pkg::*;
#(
  parameter bit DIRECT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [VAL_W-1:0]  wdata,
  output logic [PAGE_W-1:0] page_q
);
  generate
    if (DIRECT) begin : g_none
      logic unused_in;
      assign unused_in = wr ^ (^wdata) ^ clk ^ rst_n;
      assign page_q    = '0;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  page_q <= '0;
        else if (wr) page_q <= wdata[PAGE_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/csr_window_store.sv
module csr_window_store
  import csr_window_pkg::*;
#(
  parameter int IMPL_DEVS = 4,
  parameter int IMPL_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [CSR_AW-1:0] rd_addr,
  input  logic              we,
  input  logic [CSR_AW-1:0] wr_addr,
  input  logic [VAL_W-1:0]  wdata,
  output logic [VAL_W-1:0]  rdata_q
);
  localparam int DEPTH = IMPL_DEVS * IMPL_REGS;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic backed(input logic [CSR_AW-1:0] a);
    return (32'(csr_dev(a)) < 32'(IMPL_DEVS)) && (32'(csr_reg(a)) < 32'(IMPL_REGS));
  endfunction

  function automatic logic [IW-1:0] slot(input logic [CSR_AW-1:0] a);
    logic [31:0] full;
    full = 32'(csr_dev(a)) * 32'(IMPL_REGS) + 32'(csr_reg(a));
    return full[IW-1:0];
  endfunction

  logic [VAL_W-1:0] mem [DEPTH];
  logic             rd_hit;
  logic             wr_hit;

  assign rd_hit = backed(rd_addr);
  assign wr_hit = we && backed(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[slot(wr_addr)] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_hit ? mem[slot(rd_addr)] : '0;
  end

endmodule

// File: rtl/csr_window_bridge.sv
module csr_window_bridge
  import csr_window_pkg::*;
#(
  parameter int PADDR_W   = 32,
  parameter bit DIRECT    = 1'b0,
  parameter int STRIDE    = 4,
  parameter int IMPL_DEVS = 4,
  parameter int IMPL_REGS = 16,
  localparam int DW       = 8 * STRIDE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [DW-1:0]      pwdata,
  output logic [DW-1:0]      prdata,
  output logic               pready,
  output logic               pslverr
);
  // named events used by the checker
  logic              setup_phase;
  logic              access_phase;
  logic              page_wr;
  logic              store_we;
  logic              rd_ok;
  logic [PAGE_W-1:0] page_q;
  logic [VAL_W-1:0]  store_q;
  logic [VAL_W-1:0]  wval;
  logic [VAL_W-1:0]  rval;
  dec_t              dec;

  assign setup_phase  = psel && !penable;
  assign access_phase = psel && penable;
  assign wval         = pwdata[VAL_W-1:0];

  csr_window_decode #(.PADDR_W(PADDR_W), .DIRECT(DIRECT), .STRIDE(STRIDE)) u_dec (
    .paddr (paddr),
    .page  (page_q),
    .dec   (dec)
  );

  assign page_wr  = access_phase && pwrite && dec.ok && dec.page_sel;
  assign store_we = access_phase && pwrite && dec.ok && !dec.page_sel;

  csr_window_page #(.DIRECT(DIRECT)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (page_wr),
    .wdata  (wval),
    .page_q (page_q)
  );

  csr_window_store #(.IMPL_DEVS(IMPL_DEVS), .IMPL_REGS(IMPL_REGS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (setup_phase),
    .rd_addr (dec.csr),
    .we      (store_we),
    .wr_addr (dec.csr),
    .wdata   (wval),
    .rdata_q (store_q)
  );

  assign rd_ok   = access_phase && !pwrite && dec.ok;
  assign rval    = dec.page_sel ? VAL_W'(page_q) : store_q;
  assign prdata  = rd_ok ? DW'(rval) : '0;
  assign pready  = access_phase;
  assign pslverr = access_phase && !dec.ok;

endmodule

// File: rtl/csr_window_bridge_chk.sv
module csr_window_bridge_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pready,
  input logic          pslverr,
  input logic [DW-1:0] prdata,
  input logic [12:0]   page_q,
  input logic          page_wr,
  input logic          store_we
);
  p_ready_in_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pready == (psel && penable));

  p_err_only_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable));

  p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == '0));

  p_no_write_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> !(store_we || page_wr));

  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !page_wr |=> $stable(page_q));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> (prdata == '0 && !pslverr));

  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({page_wr, store_we}) <= 1);
endmodule

bind csr_window_bridge csr_window_bridge_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .psel     (psel),
  .penable  (penable),
  .pready   (pready),
  .pslverr  (pslverr),
  .prdata   (prdata),
  .page_q   (page_q),
  .page_wr  (page_wr),
  .store_we (store_we)
);

// File: tb/csr_window_bridge_test.sv
module csr_window_bridge_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [31:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata_a;
  logic        pready_a, pslverr_a;
  logic [15:0] prdata_b;
  logic        pready_b, pslverr_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int unsigned mem_a [int];
  int unsigned mem_b [int];
  int          page_a = 0;

  always #(PERIOD/2) clk = ~clk;

  // windowed, 4-byte spacing
  csr_window_bridge #(.DIRECT(1'b0), .STRIDE(4)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a), .pslverr(pslverr_a)
  );

  // flat, 2-byte spacing
  csr_window_bridge #(.DIRECT(1'b1), .STRIDE(2)) uut_flat (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata[15:0]), .prdata(prdata_b), .pready(pready_b), .pslverr(pslverr_b)
  );

  task automatic check(input string req, input string what, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  function automatic bit is_backed(input int csr);
    return ((csr >> 16) < 4) && ((csr & 32'hFFFF) < 16);
  endfunction

  // idle outputs, every clock
  always @(negedge clk) begin
    if (!psel && !done) begin
      check("R9", "idle prdata a", prdata_a, 0);
      check("R9", "idle prdata b", prdata_b, 0);
      check("R9", "idle pslverr", {pslverr_a, pslverr_b}, 0);
      check("R7", "idle pready", {pready_a, pready_b}, 0);
    end
  end

  task automatic xfer(input bit w, input logic [31:0] a, input logic [31:0] d, input string req);
    longint idx_a, idx_b;
    bit err_a, err_b, pg_a;
    int csr_a, csr_b;
    longint exp_a, exp_b;
    idx_a = longint'(a) >> 2;
    idx_b = longint'(a) >> 1;
    err_a = (a[1:0] != 0) || (idx_a >= 256);
    err_b = a[0] || (idx_b >= (64'd1 << 21));
    pg_a  = (idx_a % 256) == 255;
    csr_a = page_a * 256 + int'(idx_a % 256);
    csr_b = int'(idx_b & 64'h1FFFFF);
    exp_a = 0;
    exp_b = 0;
    if (!w && !err_a)
      exp_a = pg_a ? page_a : (is_backed(csr_a) && mem_a.exists(csr_a) ? mem_a[csr_a] : 0);
    if (!w && !err_b)
      exp_b = (is_backed(csr_b) && mem_b.exists(csr_b)) ? mem_b[csr_b] : 0;

    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(negedge clk);
    check(req, "prdata windowed", prdata_a, exp_a);
    check(req, "prdata flat", prdata_b, exp_b);
    check(req, "pslverr windowed", pslverr_a, err_a);
    check(req, "pslverr flat", pslverr_b, err_b);
    check("R7", "pready", {pready_a, pready_b}, 2'b11);
    if (w && !err_a) begin
      if (pg_a) page_a = d & 32'h1FFF;
      else if (is_backed(csr_a)) mem_a[csr_a] = d & 32'hFFFF;
    end
    if (w && !err_b && is_backed(csr_b)) mem_b[csr_b] = d & 32'hFFFF;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: got=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9/R3: reset state
    xfer(0, 32'h3FC, 0, "R3");
    xfer(0, 32'h000, 0, "R9");
    xfer(0, 32'h03C, 0, "R9");
    // R4: upper data half dropped, upper read half zero
    xfer(1, 32'h000, 32'hDEADBEEF, "R4");
    xfer(0, 32'h000, 0, "R4");
    xfer(1, 32'h004, 32'h12345678, "R4");
    xfer(0, 32'h004, 0, "R7");
    xfer(0, 32'h002, 0, "R4");
    // R3: page write keeps 13 bits, reads back
    xfer(1, 32'h3FC, 32'hFFFFFFF2, "R3");
    xfer(0, 32'h3FC, 0, "R3");
    xfer(0, 32'h004, 0, "R8");
    // R2: page 0x200 reaches device 2
    xfer(1, 32'h3FC, 32'h00000200, "R2");
    xfer(1, 32'h014, 32'h0000A5A5, "R2");
    xfer(0, 32'h014, 0, "R2");
    xfer(1, 32'h3FC, 32'h00000000, "R2");
    xfer(0, 32'h014, 0, "R2");
    // R1: flat addressing of device 3 register 3
    xfer(1, 32'h00060006, 32'h00007E57, "R1");
    xfer(0, 32'h00060006, 0, "R1");
    // R5: misaligned writes ignored
    xfer(1, 32'h001, 32'h0000FFFF, "R5");
    xfer(1, 32'h002, 32'h00001111, "R5");
    xfer(0, 32'h000, 0, "R5");
    xfer(0, 32'h002, 0, "R5");
    // R6: beyond window
    xfer(1, 32'h400, 32'h00002222, "R6");
    xfer(1, 32'h00400000, 32'h00003333, "R6");
    xfer(0, 32'h00400000, 0, "R6");
    xfer(0, 32'h000, 0, "R6");
    // R8: unbacked register
    xfer(1, 32'h040, 32'h00004444, "R8");
    xfer(0, 32'h040, 0, "R8");
    // mixed stream
    for (int i = 0; i < 300; i++) begin
      int unsigned k;
      logic [31:0] a, d;
      k = $urandom % 7;
      d = $urandom;
      case (k)
        0: a = ($urandom % 20) * 4;
        1: begin a = 32'h3FC; d = (d & 32'hFFFFE000) | (($urandom % 5) << 8); end
        2: a = ((($urandom % 5) << 16) | ($urandom % 18)) * 2;
        3: a = ($urandom % 64) | 32'h1;
        4: a = 32'h00400000 + ($urandom % 16) * 4;
        5: a = 32'h400 + ($urandom % 8) * 4;
        default: a = ($urandom % 256) * 4;
      endcase
      xfer($urandom % 2, a, d, "R7");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule